// File: doc/BRIEF.md
# Staged Shadow Control Register for a Three-Phase PWM Generator

This block holds the run-time settings of a three-phase PWM waveform generator. Software writes three byte-wide staging registers one at a time over a plain address, data and write-strobe port. A write to a fourth address carries no data of its own. That write copies all three staging bytes together into a single active control word. The active word alone drives the generator.

Because the copy happens in one cycle, a field split across two staging bytes never reaches the generator half-updated. The 12-bit frequency select is such a field. The active word is decoded into these outputs:

- the frequency select;
- the amplitude byte;
- a 9-bit extended amplitude whose top bit is the overmodulation flag;
- an output-enable flag, which is the inverse of an active-low inhibit;
- a phase-direction flag.

Top module: `pwm_ctrl_shadow`

## Requirements
- R1: After reset every staged and active bit is zero. Therefore `freq_sel`, `amp_word`, `amp_ext`, `over_mod` and `dir_reverse` read 0, and `out_enable` reads 0, meaning the outputs are held off.
- R2: A strobed write to address 0, 1 or 2 changes no decoded output.
- R3: A strobed write to address 3 copies the three staging bytes into the active word. The decoded outputs show the new value after that clock edge and not before.
- R4: `freq_sel` equals {stage1[3:0], stage0[7:0]}, with stage0 bit 0 as the least significant bit.
- R5: In stage1, bit 5 drives `out_enable` (0 = outputs off), bit 6 drives `over_mod`, and bit 7 drives `dir_reverse` (0 = forward, 1 = reverse). Bit 4 has no effect on any output.
- R6: `amp_word` equals stage2. `amp_ext` equals stage2 plus 256 when `over_mod` is 1, and stage2 alone when it is 0.
- R7: The data byte presented with an address-3 write is ignored.
- R8: Staging bytes keep their values across commits. Rewriting one byte and committing changes only the fields that byte feeds.
- R9: With `wr_en` low, no address or data value alters the staging bytes or the active word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | 0..2 select a staging byte, 3 commits |
| wr_data | input | 8 | Byte written to the selected staging register |
| freq_sel | output | 12 | Active frequency select |
| amp_word | output | 8 | Active amplitude byte |
| amp_ext | output | 9 | Amplitude with overmodulation as bit 8 |
| over_mod | output | 1 | Overmodulation flag |
| out_enable | output | 1 | 1 = PWM outputs running, 0 = inhibited |
| dir_reverse | output | 1 | 1 = reverse phase order |

## Verification
A staging write lands on the clock edge that samples the strobe and changes no output at all. A commit is due one edge after its strobe. The bench drives every write on a falling edge. It samples the old value half a cycle before the committing edge, and then samples the new value at the next falling edge. Sweeps run over all 256 values of stage1 and all 256 amplitude bytes, with the expected fields computed by shifts and adds from the bytes the bench wrote.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

   typedef enum logic [1:0] {
      SEL_FREQ_LO = 2'd0,
      SEL_FREQ_HI = 2'd1,
      SEL_AMP     = 2'd2,
      SEL_COMMIT  = 2'd3
   } shadow_sel_e;

   localparam int unsigned STAGE_COUNT = 3;

endpackage

// File: rtl/shadow_wr_decode.sv
module shadow_wr_decode
   import pwm_shadow_pkg::*;
#(
   parameter int N_STAGE = STAGE_COUNT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_addr,
   output logic [N_STAGE-1:0] stage_we,
   output logic               commit
);

   for (genvar i = 0; i < N_STAGE; i++) begin : g_we
      assign stage_we[i] = wr_en && (wr_addr == 2'(i));
   end

   assign commit = wr_en && (shadow_sel_e'(wr_addr) == SEL_COMMIT);

   // R9: no strobe, no enable of any kind
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> ({stage_we, commit} == '0));

   // R3: a commit never coincides with a staging write
   assert_commit_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stage_we, commit}));

endmodule

// File: rtl/shadow_stage_bank.sv
module shadow_stage_bank #(
   parameter int DATA_W  = 8,
   parameter int N_STAGE = 3,
   localparam int FLAT_W = DATA_W * N_STAGE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_STAGE-1:0] stage_we,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [FLAT_W-1:0]  stage_q
);

   for (genvar i = 0; i < N_STAGE; i++) begin : g_stage
      logic [DATA_W-1:0] q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           q <= '0;
         else if (stage_we[i]) q <= wr_data;
      end

      assign stage_q[i*DATA_W +: DATA_W] = q;

      // R8: an unaddressed staging byte keeps its value
      assert_stage_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !stage_we[i] |=> $stable(stage_q[i*DATA_W +: DATA_W]));
   end

endmodule

// File: rtl/shadow_active_reg.sv
module shadow_active_reg #(
   parameter int WIDTH = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit,
   input  logic [WIDTH-1:0] stage_flat,
   output logic [WIDTH-1:0] active_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      active_q <= '0;
      else if (commit) active_q <= stage_flat;
   end

   // R3: after a commit the active word equals the staging bytes sampled at that edge
   assert_commit_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (active_q == $past(stage_flat)));

   // R2: without a commit the active word holds
   assert_active_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(active_q));

endmodule

// File: rtl/pwm_ctrl_shadow.sv
module pwm_ctrl_shadow
   import pwm_shadow_pkg::*;
#(
   parameter int  DATA_W    = 8,
   parameter int  FREQ_HI_W = 4,
   localparam int FREQ_W    = DATA_W + FREQ_HI_W,
   localparam int AMP_X_W   = DATA_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [FREQ_W-1:0]  freq_sel,
   output logic [DATA_W-1:0]  amp_word,
   output logic [AMP_X_W-1:0] amp_ext,
   output logic               over_mod,
   output logic               out_enable,
   output logic               dir_reverse
);

   localparam int N_STAGE = STAGE_COUNT;
   localparam int ACT_W   = N_STAGE * DATA_W;
   localparam int BIT_EN  = DATA_W - 3;
   localparam int BIT_OM  = DATA_W - 2;
   localparam int BIT_REV = DATA_W - 1;

   if (FREQ_HI_W < 1 || DATA_W < FREQ_HI_W + 4) begin : g_bad_cfg
      $error("pwm_ctrl_shadow: stage1 cannot hold FREQ_HI_W bits plus four flags");
   end

   logic [N_STAGE-1:0] stage_we;
   logic               commit;
   logic [ACT_W-1:0]   stage_flat;
   logic [ACT_W-1:0]   active_q;
   logic [DATA_W-1:0]  act_lo, act_hi, act_amp;

   shadow_wr_decode #(.N_STAGE(N_STAGE)) u_dec (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .stage_we(stage_we), .commit(commit)
   );

   shadow_stage_bank #(.DATA_W(DATA_W), .N_STAGE(N_STAGE)) u_stage (
      .clk(clk), .rst_n(rst_n), .stage_we(stage_we), .wr_data(wr_data),
      .stage_q(stage_flat)
   );

   shadow_active_reg #(.WIDTH(ACT_W)) u_act (
      .clk(clk), .rst_n(rst_n), .commit(commit), .stage_flat(stage_flat),
      .active_q(active_q)
   );

   assign act_lo  = active_q[0*DATA_W +: DATA_W];
   assign act_hi  = active_q[1*DATA_W +: DATA_W];
   assign act_amp = active_q[2*DATA_W +: DATA_W];

   assign freq_sel    = {act_hi[FREQ_HI_W-1:0], act_lo};
   assign amp_word    = act_amp;
   assign over_mod    = act_hi[BIT_OM];
   assign out_enable  = act_hi[BIT_EN];
   assign dir_reverse = act_hi[BIT_REV];
   assign amp_ext     = {act_hi[BIT_OM], act_amp};

   // R2: a staging write leaves every generator field unchanged
   assert_stage_no_effect_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && shadow_sel_e'(wr_addr) != SEL_COMMIT) |=>
         $stable({freq_sel, amp_word, amp_ext, over_mod, out_enable, dir_reverse}));

   // R9: an idle cycle leaves every generator field unchanged
   assert_idle_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable({freq_sel, amp_ext, out_enable, dir_reverse}));

endmodule

// File: tb/sim_pwm_ctrl_shadow.sv
module sim_pwm_ctrl_shadow;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [11:0] freq_sel;
   logic [7:0]  amp_word;
   logic [8:0]  amp_ext;
   logic        over_mod, out_enable, dir_reverse;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [7:0] m_stage [3];
   logic [7:0] m_act   [3];

   always #4 clk = ~clk;

   pwm_ctrl_shadow u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .freq_sel(freq_sel), .amp_word(amp_word), .amp_ext(amp_ext),
      .over_mod(over_mod), .out_enable(out_enable), .dir_reverse(dir_reverse)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic chk_all(input string req);
      int ef, ea, ex;
      ef = {m_act[1][3:0], m_act[0]};
      ea = m_act[2];
      ex = ea + (m_act[1][6] ? 256 : 0);
      chk(req, "freq_sel",    freq_sel,    ef);
      chk(req, "amp_word",    amp_word,    ea);
      chk(req, "amp_ext",     amp_ext,     ex);
      chk(req, "over_mod",    over_mod,    m_act[1][6]);
      chk(req, "out_enable",  out_enable,  m_act[1][5]);
      chk(req, "dir_reverse", dir_reverse, m_act[1][7]);
   endtask

   // drive on a falling edge, let one rising edge sample, return at the next falling edge
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      if (a == 2'd3) begin
         #1 chk("R3", "unchanged before commit edge", freq_sel, {m_act[1][3:0], m_act[0]});
      end
      @(negedge clk);
      wr_en = 1'b0;
      if (a == 2'd3) begin
         for (int k = 0; k < 3; k++) m_act[k] = m_stage[k];
      end else begin
         m_stage[a] = d;
      end
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 3; k++) begin
         m_stage[k] = 8'd0;
         m_act[k]   = 8'd0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_all("R1");

      // R4 R5 R7: sweep every stage1 value, R7 commit data varies
      for (int v = 0; v < 256; v++) begin
         wr(2'd0, 8'(v) ^ 8'h5A);
         wr(2'd1, 8'(v));
         chk_all("R2");
         wr(2'd3, ~8'(v));
         chk_all("R4");
         chk("R5", "bit4 no effect on freq", freq_sel, {v[3:0], 8'(v) ^ 8'h5A});
      end

      // R6: every amplitude with overmodulation alternating
      for (int a = 0; a < 256; a++) begin
         wr(2'd2, 8'(a));
         wr(2'd1, {1'b0, a[0], 1'b1, 5'd3});
         wr(2'd3, 8'hFF);
         chk_all("R6");
         chk("R6", "amp_ext arith", amp_ext, a + (a[0] ? 256 : 0));
      end

      // R8: partial update keeps other bytes
      wr(2'd1, 8'hE9);
      wr(2'd2, 8'h33);
      wr(2'd3, 8'h00);
      wr(2'd0, 8'hC4);
      wr(2'd3, 8'h00);
      chk("R8", "freq hi retained", freq_sel, 12'h9C4);
      chk("R8", "amp retained", amp_word, 8'h33);
      wr(2'd3, 8'hAA);
      chk_all("R8");

      // R9: strobe low at every address
      for (int a = 0; a < 4; a++) begin
         @(negedge clk);
         wr_addr = 2'(a); wr_data = 8'h17; wr_en = 1'b0;
         @(negedge clk);
         chk_all("R9");
      end
      wr(2'd3, 8'h00);
      chk_all("R9");
      chk("R7", "commit data ignored", freq_sel, 12'h9C4);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule